// File: doc/BRIEF.md
# Multiply and Multiply-Accumulate Unit

This block is a small arithmetic coprocessor that sits beside a processor core. The core reaches it through a window of three 32-bit register slots, numbered 25, 26 and 27. It moves data in and out of that window one byte lane at a time. Slot 25 is the control word. Slots 26 and 27 present the low and high halves of a 64-bit product. The two multiplicands arrive on dedicated operand inputs, which the core feeds from its registers 28 and 29. A cycle enable marks each core cycle in which the unit may advance.

The unit has two modes. In multiply-only mode it multiplies the operand inputs on every enabled cycle and keeps its accumulator at zero. In accumulate mode it holds its state until the core writes slot 25. Each such write samples the operands and adds their product into a 64-bit accumulator. The new sum appears in the product slots. A sticky carry bit records a wrap of the accumulator. The core clears that bit by writing a one to it, and the same write also empties the accumulator.

A transfer names a start slot, a start lane within that slot and a byte count. A transfer that falls outside the window is refused and reported.

Top module: `mulacc_unit`

## Requirements
- R1: After reset the product is zero and slot 25 reads as zero, which selects multiply-only mode with the carry bit clear. The rd_valid, rd_mask, rd_data and x_err outputs are zero.
- R2: In multiply-only mode, each enabled cycle sets the product output to op_a*op_b of that cycle, visible one clock later, and forces the accumulator to zero.
- R3: In a cycle with cyc_en low, the product, slot 25 and the accumulator hold their values. Transfer requests are ignored, and rd_valid and x_err read zero on the following clock.
- R4: Bit 0 of slot 25 selects the mode: 0 for multiply-only, 1 for accumulate. In accumulate mode the product holds across cycles that do not write slot 25.
- R5: In accumulate mode (after the write is applied), a write that touches any lane of slot 25 forms sum = accumulator + op_a*op_b of that cycle. The sum goes to both the accumulator and the product, modulo 2^64.
- R6: When the sum of R5 wraps past 2^64, bit 1 of slot 25 (carry) becomes 1 and stays set.
- R7: A write of lane 0 of slot 25 whose bit 1 is 1, made while carry is set, clears carry and zeroes the accumulator. In accumulate mode the accumulation of that same write then starts from zero. Writing bit 1 has no other effect.
- R8: A read transfer returns, one clock later with rd_valid high, the chosen bytes of the window image. Slot 25 reads as its stored word: mode in bit 0, carry in bit 1, and the other bits as last written. Slot 26 is the product low half and slot 27 the high half. The read sees the state from before its own cycle. Lanes outside the transfer read zero and their rd_mask bits are zero.
- R9: A transfer whose start slot is below 25, or whose last byte lies past lane 3 of slot 27, raises x_err for one clock. It changes no state and gives no rd_valid.
- R10: A transfer covers x_len consecutive lanes. It begins at lane x_lane of slot x_reg and wraps from lane 3 into lane 0 of the next slot. Window lane k is slot 25+k/4, lane k%4, carried on bits 8k+7..8k of x_wdata, rd_data and bit k of rd_mask.
- R11: A write to lanes of slots 26 and 27 replaces those product bytes in accumulate mode when slot 25 is not touched in the same transfer. In multiply-only mode the write is overwritten by that cycle's product. The accumulator is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Core cycle enable; the unit advances only when high |
| op_a | input | 32 | First multiplicand (core register 28) |
| op_b | input | 32 | Second multiplicand (core register 29) |
| x_valid | input | 1 | Transfer request in this cycle |
| x_dir | input | 1 | 1 = core writes window, 0 = core reads window |
| x_reg | input | 5 | Start slot index of the transfer |
| x_lane | input | 2 | Start byte lane within the start slot |
| x_len | input | 5 | Number of bytes moved |
| x_wdata | input | 96 | Write bytes, window lane k on bits 8k+7..8k |
| rd_valid | output | 1 | Read data valid (one clock after the read) |
| rd_mask | output | 12 | Lanes returned by the read |
| rd_data | output | 96 | Read bytes, window lane k on bits 8k+7..8k |
| x_err | output | 1 | Refused transfer, one clock after the request |
| prod | output | 64 | Current product / accumulated sum |

## Verification
The bench builds the unit with its default sizes: 32-bit words, 5-bit slot indices and 5-bit byte counts. Slot indices can therefore name slots below the window and past it. Byte counts reach well beyond the twelve window bytes, so both refusal rules and a zero-length transfer are reachable. With full 32-bit operands, two all-ones products in accumulate mode wrap the 64-bit sum. This makes the carry bit and its clearing write reachable within a few cycles.

// File: rtl/mulacc_pkg.sv
package mulacc_pkg;
  // bit positions inside the control slot
  localparam int MODE_BIT  = 0;
  localparam int CARRY_BIT = 1;

  typedef enum logic {
    XF_READ  = 1'b0,
    XF_WRITE = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/mulacc_xfer_dec.sv
module mulacc_xfer_dec #(
  parameter int IDX_W  = 5,
  parameter int LANE_W = 2,
  parameter int LEN_W  = 5,
  parameter int LANES  = 4,
  parameter int BASE   = 25,
  parameter int REGS   = 3,
  parameter int NL     = REGS * LANES
) (
  input  logic [IDX_W-1:0]  x_reg,
  input  logic [LANE_W-1:0] x_lane,
  input  logic [LEN_W-1:0]  x_len,
  output logic              bad,
  output logic [NL-1:0]     span
);
  localparam int AW    = 16;
  localparam int FIRST = BASE * LANES;
  localparam int LIMIT = (BASE + REGS) * LANES;

  logic [AW-1:0] start_a;
  logic [AW-1:0] stop_a;

  always_comb begin
    start_a = AW'(x_reg) * AW'(LANES) + AW'(x_lane);
    stop_a  = start_a + AW'(x_len);
    bad     = (AW'(x_reg) < AW'(BASE)) || (stop_a > AW'(LIMIT));
  end

  for (genvar k = 0; k < NL; k++) begin : g_span
    assign span[k] = !bad && (AW'(FIRST + k) >= start_a) && (AW'(FIRST + k) < stop_a);
  end
endmodule

// File: rtl/mulacc_arith.sv
module mulacc_arith #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [2*W-1:0] base,
  output logic [2*W-1:0] mul,
  output logic [2*W-1:0] sum,
  output logic           wrap
);
  logic [2*W:0] ext;

  assign mul  = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  assign ext  = {1'b0, base} + {1'b0, mul};
  assign sum  = ext[2*W-1:0];
  assign wrap = ext[2*W];
endmodule

// File: rtl/mulacc_unit.sv
module mulacc_unit
  import mulacc_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int IDX_W    = 5,
  parameter int LEN_W    = 5,
  parameter int BASE_IDX = 25
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cyc_en,
  input  logic [WORD_W-1:0]          op_a,
  input  logic [WORD_W-1:0]          op_b,
  input  logic                       x_valid,
  input  logic                       x_dir,
  input  logic [IDX_W-1:0]           x_reg,
  input  logic [$clog2(WORD_W/8)-1:0] x_lane,
  input  logic [LEN_W-1:0]           x_len,
  input  logic [3*WORD_W-1:0]        x_wdata,
  output logic                       rd_valid,
  output logic [3*(WORD_W/8)-1:0]    rd_mask,
  output logic [3*WORD_W-1:0]        rd_data,
  output logic                       x_err,
  output logic [2*WORD_W-1:0]        prod
);
  localparam int LANES  = WORD_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int REGS   = 3;             // control slot + two product halves
  localparam int NL     = REGS * LANES;
  localparam int WIN_W  = NL * 8;
  localparam int PROD_W = 2 * WORD_W;

  // state
  logic [WORD_W-1:0] ctl_q;
  logic [PROD_W-1:0] prod_q;
  logic [PROD_W-1:0] acc_q;
  logic              rd_valid_q;
  logic [NL-1:0]     rd_mask_q;
  logic [WIN_W-1:0]  rd_data_q;
  logic              err_q;

  // transfer decode
  logic          bad;
  logic [NL-1:0] span;

  mulacc_xfer_dec #(
    .IDX_W (IDX_W),
    .LANE_W(LANE_W),
    .LEN_W (LEN_W),
    .LANES (LANES),
    .BASE  (BASE_IDX),
    .REGS  (REGS),
    .NL    (NL)
  ) u_dec (
    .x_reg (x_reg),
    .x_lane(x_lane),
    .x_len (x_len),
    .bad   (bad),
    .span  (span)
  );

  logic          wr_go, rd_go;
  logic [NL-1:0] wr_span;

  assign wr_go   = x_valid && (xfer_dir_e'(x_dir) == XF_WRITE) && !bad;
  assign rd_go   = x_valid && (xfer_dir_e'(x_dir) == XF_READ) && !bad;
  assign wr_span = wr_go ? span : '0;

  // window image and byte-lane merge / select
  logic [WIN_W-1:0] win_cur, win_new, rd_lanes;
  assign win_cur = {prod_q, ctl_q};

  for (genvar k = 0; k < NL; k++) begin : g_lane
    assign win_new[8*k +: 8]  = wr_span[k] ? x_wdata[8*k +: 8] : win_cur[8*k +: 8];
    assign rd_lanes[8*k +: 8] = span[k] ? win_cur[8*k +: 8] : 8'h00;
  end

  // arithmetic
  logic              ctl_hit, clr, mode_n, carry_keep, wrap;
  logic [PROD_W-1:0] base, mul, sum;

  assign ctl_hit    = |wr_span[LANES-1:0];
  assign clr        = wr_span[0] && x_wdata[CARRY_BIT] && ctl_q[CARRY_BIT];
  assign mode_n     = win_new[MODE_BIT];
  assign carry_keep = ctl_q[CARRY_BIT] && !clr;
  assign base       = clr ? '0 : acc_q;

  mulacc_arith #(.W(WORD_W)) u_arith (
    .a   (op_a),
    .b   (op_b),
    .base(base),
    .mul (mul),
    .sum (sum),
    .wrap(wrap)
  );

  // next state
  logic [WORD_W-1:0] ctl_n;
  logic [PROD_W-1:0] prod_n, acc_n;

  always_comb begin
    ctl_n            = win_new[WORD_W-1:0];
    ctl_n[MODE_BIT]  = mode_n;
    ctl_n[CARRY_BIT] = carry_keep;
    prod_n           = win_new[WIN_W-1:WORD_W];
    acc_n            = acc_q;
    if (!mode_n) begin
      prod_n = mul;
      acc_n  = '0;
    end else if (ctl_hit) begin
      prod_n           = sum;
      acc_n            = sum;
      ctl_n[CARRY_BIT] = carry_keep || wrap;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= '0;
      prod_q     <= '0;
      acc_q      <= '0;
      rd_valid_q <= 1'b0;
      rd_mask_q  <= '0;
      rd_data_q  <= '0;
      err_q      <= 1'b0;
    end else if (cyc_en) begin
      ctl_q      <= ctl_n;
      prod_q     <= prod_n;
      acc_q      <= acc_n;
      rd_valid_q <= rd_go;
      rd_mask_q  <= rd_go ? span : '0;
      rd_data_q  <= rd_go ? rd_lanes : '0;
      err_q      <= x_valid && bad;
    end else begin
      rd_valid_q <= 1'b0;
      rd_mask_q  <= '0;
      rd_data_q  <= '0;
      err_q      <= 1'b0;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_mask  = rd_mask_q;
  assign rd_data  = rd_data_q;
  assign x_err    = err_q;
  assign prod     = prod_q;
endmodule

// File: rtl/mulacc_unit_chk.sv
module mulacc_unit_chk #(
  parameter int WORD_W = 32,
  parameter int NL     = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                cyc_en,
  input logic                x_valid,
  input logic [WORD_W-1:0]   op_a,
  input logic [WORD_W-1:0]   op_b,
  input logic                mode,
  input logic [2*WORD_W-1:0] acc,
  input logic [2*WORD_W-1:0] prod,
  input logic                rd_valid,
  input logic [NL-1:0]       rd_mask,
  input logic                x_err
);
  // R2
  mult_prod_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_en && !mode && !x_valid) |=> prod == ((2*WORD_W)'($past(op_a)) * (2*WORD_W)'($past(op_b))));

  // R2
  mult_acc_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_en && !mode && !x_valid) |=> acc == '0);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cyc_en |=> ($stable(prod) && $stable(acc) && !rd_valid && !x_err));

  // R4
  mac_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_en && mode && !x_valid) |=> ($stable(prod) && $stable(acc)));

  // R9
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    x_err |-> (!rd_valid && $past(x_valid)));

  // R8
  mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> rd_mask == '0);
endmodule

bind mulacc_unit mulacc_unit_chk #(.WORD_W(WORD_W), .NL(NL)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cyc_en  (cyc_en),
  .x_valid (x_valid),
  .op_a    (op_a),
  .op_b    (op_b),
  .mode    (ctl_q[0]),
  .acc     (acc_q),
  .prod    (prod),
  .rd_valid(rd_valid),
  .rd_mask (rd_mask),
  .x_err   (x_err)
);

// File: tb/mulacc_unit_bench.sv
`timescale 1ns/1ps
module mulacc_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_en = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        x_valid = 1'b0, x_dir = 1'b0;
  logic [4:0]  x_reg = '0;
  logic [1:0]  x_lane = '0;
  logic [4:0]  x_len = '0;
  logic [95:0] x_wdata = '0;
  logic        rd_valid;
  logic [11:0] rd_mask;
  logic [95:0] rd_data;
  logic        x_err;
  logic [63:0] prod;

  always #2.5 clk = ~clk;

  mulacc_unit u_mulacc_unit (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .op_a(op_a), .op_b(op_b),
    .x_valid(x_valid), .x_dir(x_dir), .x_reg(x_reg), .x_lane(x_lane),
    .x_len(x_len), .x_wdata(x_wdata), .rd_valid(rd_valid), .rd_mask(rd_mask),
    .rd_data(rd_data), .x_err(x_err), .prod(prod)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;

  // reference state from the requirements
  logic [31:0] m_ctl = '0;
  logic [63:0] m_acc = '0, m_prod = '0;
  logic        e_rdv = 1'b0, e_err = 1'b0;
  logic [11:0] e_mask = '0;
  logic [95:0] e_rdd = '0;

  task automatic model(input bit en, input bit xv, input bit xd, input int xr,
                       input int xl, input int xn, input logic [95:0] wd,
                       input logic [31:0] a, input logic [31:0] b);
    int st, sp;
    bit refused, mode_n, clr, carry, touch;
    logic [11:0] msk, wm;
    logic [95:0] win, nw;
    logic [64:0] s;
    logic [63:0] mulv;
    if (!en) begin
      e_rdv = 0; e_mask = '0; e_rdd = '0; e_err = 0;
      return;
    end
    st = xr * 4 + xl;                      // R10
    sp = st + xn;
    refused = (xr < 25) || (sp > 112);     // R9
    for (int k = 0; k < 12; k++) msk[k] = !refused && (100 + k >= st) && (100 + k < sp);
    win = {m_prod, m_ctl};
    e_err = xv && refused;
    e_rdv = xv && !xd && !refused;
    e_mask = e_rdv ? msk : '0;
    for (int k = 0; k < 12; k++) e_rdd[8*k +: 8] = e_mask[k] ? win[8*k +: 8] : 8'h00;
    wm = (xv && xd && !refused) ? msk : '0;
    for (int k = 0; k < 12; k++) nw[8*k +: 8] = wm[k] ? wd[8*k +: 8] : win[8*k +: 8];
    mode_n = nw[0];
    clr = wm[0] && wd[1] && m_ctl[1];
    carry = m_ctl[1] && !clr;
    touch = |wm[3:0];
    mulv = {32'h0, a} * {32'h0, b};
    if (!mode_n) begin
      m_prod = mulv; m_acc = '0;
    end else if (touch) begin
      s = {1'b0, (clr ? 64'h0 : m_acc)} + {1'b0, mulv};
      m_prod = s[63:0]; m_acc = s[63:0];
      carry = carry || s[64];
    end else begin
      m_prod = nw[95:32];
    end
    m_ctl = {nw[31:2], carry, mode_n};
  endtask

  task automatic compare(input string tag);
    total++;
    if (prod !== m_prod || rd_valid !== e_rdv || rd_mask !== e_mask ||
        rd_data !== e_rdd || x_err !== e_err) begin
      bad++;
      $display("FAIL %s actual prod=%h rdv=%b mask=%h data=%h err=%b expected prod=%h rdv=%b mask=%h data=%h err=%b",
               tag, prod, rd_valid, rd_mask, rd_data, x_err,
               m_prod, e_rdv, e_mask, e_rdd, e_err);
    end
  endtask

  task automatic cyc(input string tag, input bit en, input bit xv, input bit xd,
                     input int xr, input int xl, input int xn, input logic [95:0] wd,
                     input logic [31:0] a, input logic [31:0] b);
    cyc_en = en; x_valid = xv; x_dir = xd; x_reg = 5'(xr); x_lane = 2'(xl);
    x_len = 5'(xn); x_wdata = wd; op_a = a; op_b = b;
    model(en, xv, xd, xr, xl, xn, wd, a, b);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic rd(input string tag, input int xr, input int xl, input int xn);
    cyc(tag, 1, 1, 0, xr, xl, xn, '0, $urandom, $urandom);
  endtask

  task automatic wr(input string tag, input int xr, input int xl, input int xn,
                    input logic [95:0] wd, input logic [31:0] a, input logic [31:0] b);
    cyc(tag, 1, 1, 1, xr, xl, xn, wd, a, b);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 1, 0, 0, 0, 0, 0, '0, $urandom, $urandom);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R1");                               // outputs zero out of reset
    rd("R1", 25, 0, 4);                          // control slot reads zero
    for (int i = 0; i < 6; i++) idle("R2");
    cyc("R2", 1, 0, 0, 0, 0, 0, '0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    cyc("R2", 1, 0, 0, 0, 0, 0, '0, 32'h0, 32'h12345678);
    for (int i = 0; i < 3; i++)
      cyc("R3", 0, 1, i % 2, 25, 0, 4, {$urandom, $urandom, $urandom}, $urandom, $urandom);
    cyc("R3", 0, 1, 0, 24, 0, 1, '0, 1, 1);
    rd("R8", 25, 0, 12);
    rd("R10", 25, 2, 5);
    rd("R10", 27, 3, 1);
    rd("R10", 26, 1, 0);
    rd("R9", 24, 0, 1);
    wr("R9", 27, 2, 3, {96{1'b1}}, 5, 7);
    rd("R9", 31, 3, 1);
    wr("R4", 25, 0, 1, 96'h01, 32'h00010001, 32'h00000300);
    for (int i = 0; i < 3; i++) idle("R4");
    wr("R5", 25, 1, 1, 96'hAB00, 32'h00000010, 32'h00000020);
    rd("R8", 25, 0, 12);
    wr("R6", 25, 0, 1, 96'h01, 32'hFFFFFFFF, 32'hFFFFFFFF);
    wr("R6", 25, 0, 1, 96'h01, 32'hFFFFFFFF, 32'hFFFFFFFF);
    rd("R6", 25, 0, 1);
    wr("R7", 25, 0, 1, 96'h01, 32'h3, 32'h5);  // bit1 zero: carry stays
    wr("R7", 25, 0, 1, 96'h03, 32'h3, 32'h5);  // write-one clears
    rd("R7", 25, 0, 1);
    wr("R11", 26, 0, 8, {64'h0123456789ABCDEF, 32'h0}, 1, 1);
    rd("R11", 25, 0, 12);
    idle("R11");
    wr("R4", 25, 0, 1, 96'h00, 32'h9, 32'h9);
    wr("R11", 26, 2, 3, {$urandom, $urandom, $urandom}, 32'h7, 32'h6);
    for (int i = 0; i < 400; i++) begin
      bit en, xv;
      logic [31:0] a, b;
      en = ($urandom % 8) != 0;
      xv = ($urandom % 3) == 0;
      a = ($urandom % 4 == 0) ? 32'hFFFFFFFF : $urandom;
      b = ($urandom % 4 == 0) ? 32'hFFFFFFFF : $urandom;
      cyc("R5", en, xv, 1'($urandom), 24 + int'($urandom % 5), int'($urandom % 4),
          int'($urandom % 14), {$urandom, $urandom, $urandom}, a, b);
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule